// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block walks an attached DDR1 or DDR2 memory through its power-up mode programming. After a single-cycle start pulse, it latches a memory-type strap. It then plays one of two fixed command scripts. Each step raises exactly one command strobe for one cycle. At the same time it drives the mode or extended-mode value that belongs to that step. It then waits a programmed number of microseconds before the next step.

When the last wait expires, the block enables refresh with an interval of 312 and loads every DQS lane delay tap with the setting for that memory type. It raises done at the same time. These settings and done are held until the next accepted start.

The microsecond length is a parameter (clock cycles per microsecond), so the waits scale with the clock. The DRAM pins, the refresh engine and the timing registers live elsewhere.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is high and after it is released, cmd_o, mode_o, done_o, refresh_en_o, refresh_int_o and every tap lane are all zero.
- R2: The cmd_o strobes are one-hot. Bit 0 loads the mode register, bit 1 the extended mode register, bit 2 is auto refresh, bit 3 is precharge-all, bit 4 is the EMR2 update and bit 5 is the EMR3 update. Each strobe lasts one cycle.
- R3: With the strap low (DDR1), the steps are seven, in this order: precharge-all; EMR update with 0x000; mode update with 0x133; precharge-all; auto refresh; auto refresh; mode update with 0x033.
- R4: With the strap high (DDR2), the steps are thirteen, in this order: EMR2 update; EMR3 update; precharge-all; EMR2 update; EMR3 update; EMR update with 0x402; mode update with 0x143; precharge-all; auto refresh; auto refresh; mode update with 0x043; EMR update with 0x782; EMR update with 0x402.
- R5: The first strobe appears one cycle after the start pulse is sampled. Each later strobe, and the final completion, follows its predecessor by the wait of the previous step, measured in clock cycles. That wait is SHORT_US*CYC_PER_US after the first two DDR2 steps and LONG_US*CYC_PER_US after every other step.
- R6: mode_o changes only in a cycle in which a strobe is high. Steps with no value drive 0x000. mode_o holds its last value after the script ends.
- R7: At completion, refresh_en_o is 1 and refresh_int_o is 312. Every tap lane is 0x20 for DDR1 or 0x10 for DDR2. All of these appear in the same cycle that done_o rises.
- R8: done_o stays high until the next accepted start. That start clears done_o, refresh_en_o, refresh_int_o and the taps.
- R9: A start pulse that arrives while a script is running has no effect on the strobes, the values or the completion time.
- R10: The strap is sampled only when a start is accepted. Changing it during a run does not alter the script or the final tap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| ddr2_sel_i | input | 1 | Memory-type strap: 0 DDR1, 1 DDR2 |
| cmd_o | output | 6 | One-hot command strobes |
| mode_o | output | 13 | Mode / extended-mode value for the current step |
| refresh_en_o | output | 1 | Refresh enable |
| refresh_int_o | output | 10 | Refresh interval |
| tap_o | output | LANES*TAP_W (12) | Per-lane DQS delay taps, lane 0 in the low bits |
| done_o | output | 1 | Sequence complete |

## Verification
The assertions assume that the configured waits are at least two cycles long, so that successive strobes never touch. They also assume that reset is held from time zero through at least one clock edge. The bench keeps to both conditions. It uses two cycles per microsecond and holds reset for several cycles before any start. Start pulses and strap changes are driven on the falling edge. Some are placed deliberately in the middle of a run, including a start combined with a strap flip, to show that a running script only looks at its inputs when a start is accepted.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    localparam int CMD_W  = 6;
    localparam int MODE_W = 13;
    localparam int IDX_W  = 4;

    localparam int CB_MR   = 0;
    localparam int CB_EMR  = 1;
    localparam int CB_AREF = 2;
    localparam int CB_PREA = 3;
    localparam int CB_EMR2 = 4;
    localparam int CB_EMR3 = 5;

    localparam logic [MODE_W-1:0] MV_NONE       = 13'h000;
    localparam logic [MODE_W-1:0] MV_D1_EMR     = 13'h000;
    localparam logic [MODE_W-1:0] MV_D1_MR_DLL  = 13'h133;
    localparam logic [MODE_W-1:0] MV_D1_MR      = 13'h033;
    localparam logic [MODE_W-1:0] MV_D2_EMR     = 13'h402;
    localparam logic [MODE_W-1:0] MV_D2_EMR_OCD = 13'h782;
    localparam logic [MODE_W-1:0] MV_D2_MR_DLL  = 13'h143;
    localparam logic [MODE_W-1:0] MV_D2_MR      = 13'h043;

    typedef logic [CMD_W-1:0] cmd_t;

    typedef enum logic [0:0] {
        WAIT_LONG  = 1'b0,
        WAIT_SHORT = 1'b1
    } wait_kind_e;

    typedef struct packed {
        cmd_t              cmd;
        logic [MODE_W-1:0] val;
        wait_kind_e        wk;
        logic              last;
    } step_t;

    function automatic cmd_t cmd_bit(input int b);
        cmd_t c;
        c = '0;
        c[b] = 1'b1;
        return c;
    endfunction

    function automatic step_t mk_step(input int b, input logic [MODE_W-1:0] v,
                                      input wait_kind_e wk, input logic last);
        step_t s;
        s.cmd  = cmd_bit(b);
        s.val  = v;
        s.wk   = wk;
        s.last = last;
        return s;
    endfunction

    function automatic step_t ddr1_step(input logic [IDX_W-1:0] i);
        case (i)
            4'd0:    return mk_step(CB_PREA, MV_NONE,      WAIT_LONG, 1'b0);
            4'd1:    return mk_step(CB_EMR,  MV_D1_EMR,    WAIT_LONG, 1'b0);
            4'd2:    return mk_step(CB_MR,   MV_D1_MR_DLL, WAIT_LONG, 1'b0);
            4'd3:    return mk_step(CB_PREA, MV_NONE,      WAIT_LONG, 1'b0);
            4'd4:    return mk_step(CB_AREF, MV_NONE,      WAIT_LONG, 1'b0);
            4'd5:    return mk_step(CB_AREF, MV_NONE,      WAIT_LONG, 1'b0);
            4'd6:    return mk_step(CB_MR,   MV_D1_MR,     WAIT_LONG, 1'b1);
            default: return mk_step(CB_PREA, MV_NONE,      WAIT_LONG, 1'b1);
        endcase
    endfunction

    function automatic step_t ddr2_step(input logic [IDX_W-1:0] i);
        case (i)
            4'd0:    return mk_step(CB_EMR2, MV_NONE,       WAIT_SHORT, 1'b0);
            4'd1:    return mk_step(CB_EMR3, MV_NONE,       WAIT_SHORT, 1'b0);
            4'd2:    return mk_step(CB_PREA, MV_NONE,       WAIT_LONG,  1'b0);
            4'd3:    return mk_step(CB_EMR2, MV_NONE,       WAIT_LONG,  1'b0);
            4'd4:    return mk_step(CB_EMR3, MV_NONE,       WAIT_LONG,  1'b0);
            4'd5:    return mk_step(CB_EMR,  MV_D2_EMR,     WAIT_LONG,  1'b0);
            4'd6:    return mk_step(CB_MR,   MV_D2_MR_DLL,  WAIT_LONG,  1'b0);
            4'd7:    return mk_step(CB_PREA, MV_NONE,       WAIT_LONG,  1'b0);
            4'd8:    return mk_step(CB_AREF, MV_NONE,       WAIT_LONG,  1'b0);
            4'd9:    return mk_step(CB_AREF, MV_NONE,       WAIT_LONG,  1'b0);
            4'd10:   return mk_step(CB_MR,   MV_D2_MR,      WAIT_LONG,  1'b0);
            4'd11:   return mk_step(CB_EMR,  MV_D2_EMR_OCD, WAIT_LONG,  1'b0);
            4'd12:   return mk_step(CB_EMR,  MV_D2_EMR,     WAIT_LONG,  1'b1);
            default: return mk_step(CB_PREA, MV_NONE,       WAIT_LONG,  1'b1);
        endcase
    endfunction

endpackage

// File: rtl/dram_init_script.sv
module dram_init_script
    import dram_init_pkg::*;
(
    input  logic             is_ddr2,
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    step_t s1, s2;

    always_comb begin
        s1   = ddr1_step(idx);
        s2   = ddr2_step(idx);
        step = is_ddr2 ? s2 : s1;
    end
endmodule

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign zero = (count == '0);

    // R5: an unloaded, non-zero timer steps down by exactly one per cycle
    a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (count == $past(count) - 1'b1));

    // R5: a load is taken on the next cycle
    a_r5_load_taken: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int CYC_PER_US   = 100,
    parameter int LONG_US      = 100,
    parameter int SHORT_US     = 10,
    parameter int REF_W        = 10,
    parameter int REF_INTERVAL = 312,
    parameter int LANES        = 2,
    parameter int TAP_W        = 6,
    parameter int TAP_DDR1     = 'h20,
    parameter int TAP_DDR2     = 'h10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   ddr2_sel_i,
    output logic [CMD_W-1:0]       cmd_o,
    output logic [MODE_W-1:0]      mode_o,
    output logic                   refresh_en_o,
    output logic [REF_W-1:0]       refresh_int_o,
    output logic [LANES*TAP_W-1:0] tap_o,
    output logic                   done_o
);
    localparam int LONG_CYC  = LONG_US * CYC_PER_US;
    localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
    localparam int MIN_WAIT  = (SHORT_CYC < LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int TMR_W     = $clog2(LONG_CYC + SHORT_CYC + 1);
    localparam logic [TMR_W-1:0] LONG_LD  = TMR_W'(LONG_CYC - 1);
    localparam logic [TMR_W-1:0] SHORT_LD = TMR_W'(SHORT_CYC - 1);
    localparam logic [REF_W-1:0] REF_VAL  = REF_W'(REF_INTERVAL);
    localparam logic [TAP_W-1:0] TAP1     = TAP_W'(TAP_DDR1);
    localparam logic [TAP_W-1:0] TAP2     = TAP_W'(TAP_DDR2);

    logic             busy;
    logic             ddr2_q;
    logic [IDX_W-1:0] idx;
    logic [TAP_W-1:0] tap_q [LANES];

    step_t first_step, cur_step, next_step, load_step;
    logic  accept, advance, finish, tmr_zero, tmr_load;
    logic [TMR_W-1:0] tmr_val;

    dram_init_script u_first (.is_ddr2(ddr2_sel_i), .idx('0),             .step(first_step));
    dram_init_script u_cur   (.is_ddr2(ddr2_q),     .idx(idx),            .step(cur_step));
    dram_init_script u_next  (.is_ddr2(ddr2_q),     .idx(idx + 1'b1),     .step(next_step));

    always_comb begin
        accept    = !busy && start_i;
        finish    = busy && tmr_zero && cur_step.last;
        advance   = busy && tmr_zero && !cur_step.last;
        load_step = accept ? first_step : next_step;
        tmr_load  = accept || advance;
        tmr_val   = (load_step.wk == WAIT_SHORT) ? SHORT_LD : LONG_LD;
    end

    dram_init_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            ddr2_q        <= 1'b0;
            idx           <= '0;
            cmd_o         <= '0;
            mode_o        <= '0;
            done_o        <= 1'b0;
            refresh_en_o  <= 1'b0;
            refresh_int_o <= '0;
        end else begin
            cmd_o <= '0;
            if (accept) begin
                busy          <= 1'b1;
                ddr2_q        <= ddr2_sel_i;
                idx           <= '0;
                cmd_o         <= first_step.cmd;
                mode_o        <= first_step.val;
                done_o        <= 1'b0;
                refresh_en_o  <= 1'b0;
                refresh_int_o <= '0;
            end else if (advance) begin
                idx    <= idx + 1'b1;
                cmd_o  <= next_step.cmd;
                mode_o <= next_step.val;
            end else if (finish) begin
                busy          <= 1'b0;
                done_o        <= 1'b1;
                refresh_en_o  <= 1'b1;
                refresh_int_o <= REF_VAL;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || accept) begin
                tap_q[g] <= '0;
            end else if (finish) begin
                tap_q[g] <= ddr2_q ? TAP2 : TAP1;
            end
        end
        assign tap_o[g*TAP_W +: TAP_W] = tap_q[g];
    end

    // R2: never more than one command at a time
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_o));

    // R2: a strobe lasts a single cycle
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o != '0) && (MIN_WAIT > 1)) |=> (cmd_o == '0));

    // R6: the value bus moves only together with a strobe
    a_r6_mode_stable: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == '0) |-> $stable(mode_o));

    // R7: completion carries the refresh settings
    a_r7_refresh_on_done: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (refresh_en_o && refresh_int_o == REF_VAL));

    // R8: done holds until a start arrives
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    // R9: a start while running with no step due produces nothing
    a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i && !tmr_zero) |=> (cmd_o == '0 && !done_o));
endmodule

// File: tb/dram_init_seq_bench.sv
module dram_init_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPU   = 2;
    localparam int LUS   = 100;
    localparam int SUS   = 10;
    localparam int LW    = LUS * CPU;
    localparam int SW    = SUS * CPU;
    localparam int TW    = 6;
    localparam int NL    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic ddr2_sel_i = 1'b0;
    logic [5:0]       cmd_o;
    logic [12:0]      mode_o;
    logic             refresh_en_o;
    logic [9:0]       refresh_int_o;
    logic [NL*TW-1:0] tap_o;
    logic             done_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_init_seq #(.CYC_PER_US(CPU), .LONG_US(LUS), .SHORT_US(SUS)) u_dram_init_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .ddr2_sel_i(ddr2_sel_i),
        .cmd_o(cmd_o), .mode_o(mode_o), .refresh_en_o(refresh_en_o),
        .refresh_int_o(refresh_int_o), .tap_o(tap_o), .done_o(done_o));

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // reference model: expected scripts as queues of (command bit, value, wait)
    int q_bit[$];
    int q_val[$];
    int q_wait[$];

    task automatic build_script(input bit ddr2);
        q_bit.delete(); q_val.delete(); q_wait.delete();
        if (!ddr2) begin
            q_bit = '{3, 1, 0, 3, 2, 2, 0};
            q_val = '{0, 'h000, 'h133, 0, 0, 0, 'h033};
            q_wait = '{LW, LW, LW, LW, LW, LW, LW};
        end else begin
            q_bit = '{4, 5, 3, 4, 5, 1, 0, 3, 2, 2, 0, 1, 1};
            q_val = '{0, 0, 0, 0, 0, 'h402, 'h143, 0, 0, 0, 'h043, 'h782, 'h402};
            q_wait = '{SW, SW, LW, LW, LW, LW, LW, LW, LW, LW, LW, LW, LW};
        end
    endtask

    bit m_busy, m_ddr2, m_done, m_ren;
    int m_idx, m_cnt, m_cmd, m_mode, m_int, m_tap;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_ddr2 = 0; m_done = 0; m_ren = 0;
            m_idx = 0; m_cnt = 0; m_cmd = 0; m_mode = 0; m_int = 0; m_tap = 0;
        end else begin
            m_cmd = 0;
            if (!m_busy && start_i) begin
                m_ddr2 = ddr2_sel_i;
                build_script(m_ddr2);
                m_busy = 1; m_idx = 0;
                m_cmd = 1 << q_bit[0]; m_mode = q_val[0]; m_cnt = q_wait[0];
                m_done = 0; m_ren = 0; m_int = 0; m_tap = 0;
            end else if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (m_idx == q_bit.size() - 1) begin
                        m_busy = 0; m_done = 1; m_ren = 1; m_int = 312;
                        m_tap = m_ddr2 ? 'h10 : 'h20;
                    end else begin
                        m_idx++;
                        m_cmd = 1 << q_bit[m_idx]; m_mode = q_val[m_idx]; m_cnt = q_wait[m_idx];
                    end
                end
            end
        end
    end

    // every-cycle comparison plus strobe logging
    int cyc = 0;
    int n_strobes = 0;
    int last_strobe = 0;
    int gaps[$];

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            check(m_ddr2 ? "R4" : "R3", "cmd_o", int'(cmd_o), m_cmd);
            check("R6", "mode_o", int'(mode_o), m_mode);
            check("R8", "done_o", int'(done_o), int'(m_done));
            check("R7", "refresh_en_o", int'(refresh_en_o), int'(m_ren));
            check("R7", "refresh_int_o", int'(refresh_int_o), m_int);
            for (int l = 0; l < NL; l++)
                check("R7", "tap lane", int'(tap_o[l*TW +: TW]), m_tap);
            if (cmd_o != 0) begin
                if (n_strobes > 0) gaps.push_back(cyc - last_strobe);
                n_strobes++;
                last_strobe = cyc;
            end
        end
    end

    task automatic pulse_start(input bit ddr2);
        @(negedge clk);
        ddr2_sel_i = ddr2;
        start_i = 1'b1;
        n_strobes = 0;
        gaps.delete();
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "cmd_o in reset", int'(cmd_o), 0);
        check("R1", "done_o in reset", int'(done_o), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "cmd_o after reset", int'(cmd_o), 0);
        check("R1", "mode_o after reset", int'(mode_o), 0);
        check("R1", "refresh_en_o after reset", int'(refresh_en_o), 0);
        check("R1", "tap_o after reset", int'(tap_o), 0);

        // DDR1 run
        pulse_start(1'b0);
        check("R5", "first strobe one cycle after start", int'(cmd_o), 'h08);
        wait_done();
        check("R3", "DDR1 strobe count", n_strobes, 7);
        check("R5", "DDR1 spacing", gaps[0], LW);
        check("R7", "DDR1 taps", int'(tap_o), {6'h20, 6'h20});
        check("R7", "refresh interval", int'(refresh_int_o), 312);
        repeat (40) @(negedge clk);
        check("R8", "done held while idle", int'(done_o), 1);
        check("R6", "mode held after end", int'(mode_o), 'h033);

        // DDR2 run
        pulse_start(1'b1);
        check("R8", "done cleared by start", int'(done_o), 0);
        check("R2", "DDR2 first strobe is EMR2", int'(cmd_o), 'h10);
        wait_done();
        check("R4", "DDR2 strobe count", n_strobes, 13);
        check("R5", "DDR2 short gap 1", gaps[0], SW);
        check("R5", "DDR2 short gap 2", gaps[1], SW);
        check("R5", "DDR2 long gap", gaps[2], LW);
        check("R7", "DDR2 taps", int'(tap_o), {6'h10, 6'h10});

        // DDR1 run with a start and a strap flip in the middle
        pulse_start(1'b0);
        repeat (LW + 37) @(negedge clk);
        ddr2_sel_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check("R9", "strobes with start while running", n_strobes, 7);
        check("R10", "taps after mid-run strap flip", int'(tap_o), {6'h20, 6'h20});
        check("R10", "refresh after mid-run strap flip", int'(refresh_en_o), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule